// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block places accepted receive frames into a circular buffer that lives in paged packet memory. Memory is cut into 256-byte pages, and the ring covers the pages from a programmable start page up to, but not including, a programmable stop page. Frames arrive as a byte stream framed by separate start and end strobes. The end strobe carries an error flag and a group-address flag. The block turns this stream into registered memory write strobes, addresses and data.

Each kept frame takes whole pages. Its body is written first, four bytes into the current page. A four-byte header then goes into the first four bytes of that page. The header links to the page where the next frame will begin and carries the byte count. Only when the header is complete does the current-page pointer move forward. The host releases space by advancing a boundary page. A frame that would write into that page is abandoned, and the block raises overwrite and missed-frame status and keeps a tally of dropped frames. A monitor mode checks frames without storing them.

The page registers and the mode bit are loaded through a single-cycle register write port. The select codes are 0 start page, 1 stop page, 2 current page, 3 boundary page and 4 mode.

Top module: `rx_ring_mgr`

## Requirements
- R1: A byte written at offset 255 of a page is followed by a byte at offset 0 of the next page, where the page after stop-1 is the start page.
- R2: After a start strobe in idle, the frame's data bytes are written in order at consecutive addresses beginning at offset 4 of the current page. Each write appears on mem_we/mem_addr/mem_wdata one cycle after its rx_valid byte is sampled.
- R3: After a good end strobe (rx_err=0), four header writes follow on consecutive cycles at offsets 0..3 of the current page. Offset 0 holds the status byte (bit0=1, bit1=rx_group, other bits 0). Offset 1 holds the next-frame page. Offset 2 holds the low byte and offset 3 the high byte of the frame length plus 4.
- R4: In the cycle the offset-3 header byte is presented, st_rx_ok pulses and cur_page becomes the next free page. That page is the page after the last body byte, or the page holding the write pointer when the last byte filled offset 255. The current page changes only then or on a register write.
- R5: A frame ending with rx_err=1 gets no header, leaves cur_page unchanged, and neither pulses st_rx_ok nor counts as missed.
- R6: A byte that would be written into the boundary page is not written, and neither is the rest of that frame. A start strobe while cur_page equals the boundary page gets the same treatment. In both cases st_ovw and st_missed pulse, miss_cnt increments, and cur_page is unchanged.
- R7: rst_flag is set by an overwrite and stays set until the boundary register is written with a value different from its current one. Rewriting the same value leaves it set.
- R8: While mode bit0 is 1, rx_disabled is high, frames produce no memory writes, and each frame pulses st_missed and increments miss_cnt.
- R9: st_cnt_ovf pulses once, in the cycle miss_cnt's most significant bit becomes set by an increment.
- R10: After reset, mem_we, all status pulses, rst_flag, rx_disabled, cur_page and miss_cnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 start, 1 stop, 2 current, 3 boundary, 4 mode) |
| cfg_data | input | PAGE_W | Register write data; bit0 is monitor mode for select 4 |
| rx_sof | input | 1 | Frame start strobe, no data |
| rx_valid | input | 1 | Frame data byte valid |
| rx_data | input | 8 | Frame data byte |
| rx_eof | input | 1 | Frame end strobe, no data |
| rx_err | input | 1 | Frame is bad, sampled with rx_eof |
| rx_group | input | 1 | Frame was group addressed, sampled with rx_eof |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PAGE_W+8 | Packet memory byte address {page, offset} |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | PAGE_W | Page where the next frame will be placed |
| st_rx_ok | output | 1 | Pulse: frame stored |
| st_ovw | output | 1 | Pulse: ring overwrite avoided, frame dropped |
| st_missed | output | 1 | Pulse: frame missed |
| st_cnt_ovf | output | 1 | Pulse: tally MSB became set |
| rst_flag | output | 1 | Sticky overwrite reset status |
| rx_disabled | output | 1 | Monitor mode active |
| miss_cnt | output | CNT_W | Missed-frame tally |

## Verification
Each memory write is due in the cycle after the clock edge that samples its input byte. The four header writes follow the edge that samples the end strobe on consecutive cycles, and st_rx_ok and the new cur_page arrive together with the last of them. Overwrite, missed and counter-overflow pulses show up one cycle after the offending byte or start strobe is sampled. The scoreboard compares every write in the cycle it is presented, at the falling edge, in order against a queue built from a page model kept in the bench. It checks st_rx_ok against the offset-3 header write in that same sample. Register-level results are read only after a settling gap of eight cycles following each frame.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_HDR  = 2'd2,
    ST_DROP = 2'd3
  } rrm_state_e;

  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_STOP  = 3'd1;
  localparam logic [2:0] SEL_CUR   = 3'd2;
  localparam logic [2:0] SEL_BND   = 3'd3;
  localparam logic [2:0] SEL_MODE  = 3'd4;

  localparam int DATA_W   = 8;
  localparam int HDR_LEN  = 4;
  localparam int BCOUNT_W = 16;
endpackage

// File: rtl/rrm_cfg_regs.sv
module rrm_cfg_regs
  import rrm_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_data,
  input  logic              commit,
  input  logic [PAGE_W-1:0] commit_page,
  input  logic              ovw_set,
  output logic [PAGE_W-1:0] start_page,
  output logic [PAGE_W-1:0] stop_page,
  output logic [PAGE_W-1:0] cur_page,
  output logic [PAGE_W-1:0] bnd_page,
  output logic              mon_mode,
  output logic              rst_flag
);
  logic [PAGE_W-1:0] start_n, stop_n, cur_n, bnd_n;
  logic              mon_n, rflag_n, bnd_moved;

  always_comb begin
    start_n   = start_page;
    stop_n    = stop_page;
    cur_n     = cur_page;
    bnd_n     = bnd_page;
    mon_n     = mon_mode;
    bnd_moved = 1'b0;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_START: start_n = cfg_data;
        SEL_STOP:  stop_n  = cfg_data;
        SEL_CUR:   cur_n   = cfg_data;
        SEL_BND: begin
          bnd_n     = cfg_data;
          bnd_moved = (cfg_data != bnd_page);
        end
        SEL_MODE:  mon_n   = cfg_data[0];
        default: ;
      endcase
    end
    if (commit) cur_n = commit_page;
    if (ovw_set)        rflag_n = 1'b1;
    else if (bnd_moved) rflag_n = 1'b0;
    else                rflag_n = rst_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_page <= '0;
      stop_page  <= '0;
      cur_page   <= '0;
      bnd_page   <= '0;
      mon_mode   <= 1'b0;
      rst_flag   <= 1'b0;
    end else begin
      start_page <= start_n;
      stop_page  <= stop_n;
      cur_page   <= cur_n;
      bnd_page   <= bnd_n;
      mon_mode   <= mon_n;
      rst_flag   <= rflag_n;
    end
  end
endmodule

// File: rtl/rrm_tally.sv
module rrm_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             miss_pulse,
  output logic             ovf_pulse
);
  localparam logic [CNT_W-1:0] BELOW_MSB = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_n;
  logic             ovf_n;

  always_comb begin
    cnt_n = cnt;
    ovf_n = 1'b0;
    if (inc) begin
      cnt_n = cnt + 1'b1;
      ovf_n = (cnt == BELOW_MSB);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      miss_pulse <= 1'b0;
      ovf_pulse  <= 1'b0;
    end else begin
      cnt        <= cnt_n;
      miss_pulse <= inc;
      ovf_pulse  <= ovf_n;
    end
  end
endmodule

// File: rtl/rrm_wr_ctl.sv
module rrm_wr_ctl
  import rrm_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_sof,
  input  logic                    rx_valid,
  input  logic [DATA_W-1:0]       rx_data,
  input  logic                    rx_eof,
  input  logic                    rx_err,
  input  logic                    rx_group,
  input  logic [PAGE_W-1:0]       start_page,
  input  logic [PAGE_W-1:0]       stop_page,
  input  logic [PAGE_W-1:0]       cur_page,
  input  logic [PAGE_W-1:0]       bnd_page,
  input  logic                    mon_mode,
  output logic                    mem_we,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    commit,
  output logic [PAGE_W-1:0]       commit_page,
  output logic                    ovw_set,
  output logic                    miss_inc,
  output logic                    ok_pulse,
  output logic                    ovw_pulse
);
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam logic [OFF_W-1:0] BODY_OFF = OFF_W'(HDR_LEN);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  rrm_state_e          st_q, st_n;
  logic [PAGE_W-1:0]   pg_q, pg_n, nxt_q, nxt_n;
  logic [OFF_W-1:0]    off_q, off_n;
  logic [BCOUNT_W-1:0] len_q, len_n, bcount;
  logic [1:0]          idx_q, idx_n;
  logic                grp_q, grp_n;
  logic                we_n, ok_n;
  logic [ADDR_W-1:0]   addr_n;
  logic [DATA_W-1:0]   dat_n;

  function automatic logic [PAGE_W-1:0] step_page(input logic [PAGE_W-1:0] p);
    logic [PAGE_W-1:0] inc;
    inc = p + 1'b1;
    return (inc == stop_page) ? start_page : inc;
  endfunction

  assign bcount      = len_q + BCOUNT_W'(HDR_LEN);
  assign commit_page = nxt_q;

  always_comb begin
    st_n    = st_q;
    pg_n    = pg_q;
    off_n   = off_q;
    len_n   = len_q;
    nxt_n   = nxt_q;
    idx_n   = idx_q;
    grp_n   = grp_q;
    we_n    = 1'b0;
    addr_n  = mem_addr;
    dat_n   = mem_wdata;
    commit  = 1'b0;
    ok_n    = 1'b0;
    ovw_set = 1'b0;
    miss_inc = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rx_sof) begin
          if (mon_mode) begin
            miss_inc = 1'b1;
            st_n     = ST_DROP;
          end else if (cur_page == bnd_page) begin
            ovw_set  = 1'b1;
            miss_inc = 1'b1;
            st_n     = ST_DROP;
          end else begin
            st_n  = ST_BODY;
            pg_n  = cur_page;
            off_n = BODY_OFF;
            len_n = '0;
          end
        end
      end
      ST_BODY: begin
        if (rx_eof) begin
          if (rx_err) begin
            st_n = ST_IDLE;
          end else begin
            st_n  = ST_HDR;
            idx_n = 2'd0;
            grp_n = rx_group;
            nxt_n = (off_q == '0) ? pg_q : step_page(pg_q);
          end
        end else if (rx_valid) begin
          if (pg_q == bnd_page) begin
            ovw_set  = 1'b1;
            miss_inc = 1'b1;
            st_n     = ST_DROP;
          end else begin
            we_n   = 1'b1;
            addr_n = {pg_q, off_q};
            dat_n  = rx_data;
            len_n  = len_q + 1'b1;
            off_n  = off_q + 1'b1;
            if (off_q == LAST_OFF) pg_n = step_page(pg_q);
          end
        end
      end
      ST_HDR: begin
        we_n   = 1'b1;
        addr_n = {cur_page, OFF_W'(idx_q)};
        case (idx_q)
          2'd0:    dat_n = {{(DATA_W-2){1'b0}}, grp_q, 1'b1};
          2'd1:    dat_n = DATA_W'(nxt_q);
          2'd2:    dat_n = bcount[DATA_W-1:0];
          default: dat_n = bcount[2*DATA_W-1:DATA_W];
        endcase
        idx_n = idx_q + 1'b1;
        if (idx_q == 2'd3) begin
          commit = 1'b1;
          ok_n   = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: begin
        if (rx_eof) st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pg_q      <= '0;
      off_q     <= '0;
      len_q     <= '0;
      nxt_q     <= '0;
      idx_q     <= '0;
      grp_q     <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ok_pulse  <= 1'b0;
      ovw_pulse <= 1'b0;
    end else begin
      st_q      <= st_n;
      pg_q      <= pg_n;
      off_q     <= off_n;
      len_q     <= len_n;
      nxt_q     <= nxt_n;
      idx_q     <= idx_n;
      grp_q     <= grp_n;
      mem_we    <= we_n;
      mem_addr  <= addr_n;
      mem_wdata <= dat_n;
      ok_pulse  <= ok_n;
      ovw_pulse <= ovw_set;
    end
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rrm_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_sel,
  input  logic [PAGE_W-1:0]       cfg_data,
  input  logic                    rx_sof,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rx_eof,
  input  logic                    rx_err,
  input  logic                    rx_group,
  output logic                    mem_we,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic [PAGE_W-1:0]       cur_page,
  output logic                    st_rx_ok,
  output logic                    st_ovw,
  output logic                    st_missed,
  output logic                    st_cnt_ovf,
  output logic                    rst_flag,
  output logic                    rx_disabled,
  output logic [CNT_W-1:0]        miss_cnt
);
  logic [PAGE_W-1:0] start_page, stop_page, bnd_page, commit_page;
  logic              mon_mode, commit, ovw_set, miss_inc;

  rrm_cfg_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .commit(commit), .commit_page(commit_page), .ovw_set(ovw_set),
    .start_page(start_page), .stop_page(stop_page), .cur_page(cur_page),
    .bnd_page(bnd_page), .mon_mode(mon_mode), .rst_flag(rst_flag)
  );

  rrm_wr_ctl #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_err(rx_err), .rx_group(rx_group),
    .start_page(start_page), .stop_page(stop_page), .cur_page(cur_page),
    .bnd_page(bnd_page), .mon_mode(mon_mode),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .commit(commit), .commit_page(commit_page), .ovw_set(ovw_set),
    .miss_inc(miss_inc), .ok_pulse(st_rx_ok), .ovw_pulse(st_ovw)
  );

  rrm_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .inc(miss_inc),
    .cnt(miss_cnt), .miss_pulse(st_missed), .ovf_pulse(st_cnt_ovf)
  );

  assign rx_disabled = mon_mode;
endmodule

// File: rtl/rrm_checker.sv
module rrm_checker #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int CNT_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic                    mem_we,
  input logic [PAGE_W+OFF_W-1:0] mem_addr,
  input logic [PAGE_W-1:0]       cur_page,
  input logic [PAGE_W-1:0]       bnd_page,
  input logic                    st_rx_ok,
  input logic                    st_ovw,
  input logic                    st_missed,
  input logic                    st_cnt_ovf,
  input logic                    rst_flag,
  input logic [CNT_W-1:0]        miss_cnt
);
  assert_no_bnd_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[PAGE_W+OFF_W-1:OFF_W] != $past(bnd_page)));

  assert_commit_on_last_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_rx_ok |-> (mem_we && (mem_addr[OFF_W-1:0] == OFF_W'(3))));

  assert_cur_only_moves_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_rx_ok && !$past(cfg_we)) |-> $stable(cur_page));

  assert_ovw_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovw |-> rst_flag);

  assert_ovw_counts_missed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovw |-> st_missed);

  assert_miss_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_missed |-> (miss_cnt == CNT_W'($past(miss_cnt) + 1'b1)));

  assert_ovf_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_cnt_ovf |-> (st_missed && miss_cnt[CNT_W-1]));

  assert_ok_excl_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_rx_ok, st_ovw}));
endmodule

bind rx_ring_mgr rrm_checker #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mem_we(mem_we), .mem_addr(mem_addr),
  .cur_page(cur_page), .bnd_page(bnd_page), .st_rx_ok(st_rx_ok), .st_ovw(st_ovw),
  .st_missed(st_missed), .st_cnt_ovf(st_cnt_ovf), .rst_flag(rst_flag),
  .miss_cnt(miss_cnt)
);

// File: tb/sim_rx_ring_mgr.sv
`timescale 1ns/1ps
module sim_rx_ring_mgr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_data;
  logic        rx_sof, rx_valid, rx_eof, rx_err, rx_group;
  logic [7:0]  rx_data;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  cur_page;
  logic        st_rx_ok, st_ovw, st_missed, st_cnt_ovf, rst_flag, rx_disabled;
  logic [7:0]  miss_cnt;

  always #2.5 clk = ~clk;

  rx_ring_mgr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
    .rx_err(rx_err), .rx_group(rx_group), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_page(cur_page), .st_rx_ok(st_rx_ok), .st_ovw(st_ovw),
    .st_missed(st_missed), .st_cnt_ovf(st_cnt_ovf), .rst_flag(rst_flag),
    .rx_disabled(rx_disabled), .miss_cnt(miss_cnt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int n_ok = 0, n_ovw = 0, n_miss = 0, n_ovf = 0;

  logic [23:0] sbq[$];
  logic [7:0]  m_start, m_stop, m_cur, m_bnd, m_next;
  logic        m_mon;
  logic [7:0]  m_miss;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every write in the cycle it is presented
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_we) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R2 unexpected write", {mem_addr, mem_wdata}, 0);
        end else begin
          logic [23:0] e;
          e = sbq.pop_front();
          chk({mem_addr, mem_wdata} == e, "R2/R3 write addr_data", {mem_addr, mem_wdata}, e);
        end
      end
      if (st_rx_ok) begin
        n_ok++;
        chk(mem_we && mem_addr[7:0] == 8'd3, "R4 ok with last header byte", mem_addr[7:0], 3);
        chk(cur_page == m_next, "R4 cur_page at commit", cur_page, m_next);
      end
      if (st_ovw)     n_ovw++;
      if (st_missed)  n_miss++;
      if (st_cnt_ovf) n_ovf++;
    end
  end

  function automatic logic [7:0] step(input logic [7:0] p);
    return (8'(p + 1) == m_stop) ? m_start : 8'(p + 1);
  endfunction

  task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_start = d;
      3'd1: m_stop  = d;
      3'd2: m_cur   = d;
      3'd3: m_bnd   = d;
      3'd4: m_mon   = d[0];
      default: ;
    endcase
  endtask

  // driver: builds expected writes from the page model, then drives the frame
  task automatic send(input int len, input bit grp, input bit err, input int seed);
    logic [7:0] pg, off;
    bit over;
    pg = m_cur; off = 8'd4; over = 1'b0;
    if (m_mon) begin
      m_miss++;
    end else if (m_cur == m_bnd) begin
      m_miss++;
    end else begin
      for (int i = 0; i < len; i++) begin
        if (pg == m_bnd) begin over = 1'b1; break; end
        sbq.push_back({pg, off, 8'((i * 7 + seed) & 8'hFF)});
        if (off == 8'hFF) pg = step(pg);
        off = 8'(off + 1);
      end
      if (over) begin
        m_miss++;
      end else if (!err) begin
        logic [15:0] bc;
        logic [7:0]  nx;
        bc = 16'(len + 4);
        nx = (off == 8'd0) ? pg : step(pg);
        sbq.push_back({m_cur, 8'd0, 6'd0, grp, 1'b1});
        sbq.push_back({m_cur, 8'd1, nx});
        sbq.push_back({m_cur, 8'd2, bc[7:0]});
        sbq.push_back({m_cur, 8'd3, bc[15:8]});
        m_next = nx;
        m_cur  = nx;
      end
    end
    @(negedge clk);
    rx_sof = 1'b1;
    @(negedge clk);
    rx_sof = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'((i * 7 + seed) & 8'hFF);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_eof = 1'b1; rx_err = err; rx_group = grp;
    @(negedge clk);
    rx_eof = 1'b0; rx_err = 1'b0; rx_group = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int ok0, ovw0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
    rx_sof = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_eof = 1'b0; rx_err = 1'b0; rx_group = 1'b0;
    m_start = 0; m_stop = 0; m_cur = 0; m_bnd = 0; m_mon = 0; m_miss = 0; m_next = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(mem_we == 1'b0, "R10 mem_we", mem_we, 0);
    chk(cur_page == 8'd0, "R10 cur_page", cur_page, 0);
    chk(miss_cnt == 8'd0, "R10 miss_cnt", miss_cnt, 0);
    chk(rst_flag == 1'b0 && rx_disabled == 1'b0, "R10 flags", {rst_flag, rx_disabled}, 0);
    chk({st_rx_ok, st_ovw, st_missed, st_cnt_ovf} == 4'd0, "R10 pulses",
        {st_rx_ok, st_ovw, st_missed, st_cnt_ovf}, 0);

    cfg(3'd0, 8'h40); cfg(3'd1, 8'h48); cfg(3'd2, 8'h40); cfg(3'd3, 8'h47);

    // R2 R3 R4: short frame
    send(60, 1'b0, 1'b0, 3);
    chk(cur_page == 8'h41, "R4 short frame next page", cur_page, 8'h41);
    // R4: length plus header fills exactly one page
    send(252, 1'b0, 1'b0, 11);
    chk(cur_page == 8'h42, "R4 exact page fill", cur_page, 8'h42);
    // R4: one byte over a page
    send(253, 1'b0, 1'b0, 29);
    chk(cur_page == 8'h44, "R4 spill into second page", cur_page, 8'h44);
    // R1: wrap from stop-1 to start
    cfg(3'd2, 8'h47); cfg(3'd3, 8'h45);
    send(300, 1'b0, 1'b0, 5);
    chk(cur_page == 8'h41, "R1 wrapped next page", cur_page, 8'h41);
    // R5: errored frame
    ok0 = n_ok;
    send(20, 1'b0, 1'b1, 40);
    chk(cur_page == 8'h41, "R5 cur unchanged", cur_page, 8'h41);
    chk(n_ok == ok0, "R5 no ok pulse", n_ok, ok0);
    chk(miss_cnt == 8'd0, "R5 not missed", miss_cnt, 0);
    // R6 R7: overrun mid-frame
    cfg(3'd3, 8'h42);
    ovw0 = n_ovw;
    send(400, 1'b0, 1'b0, 9);
    chk(cur_page == 8'h41, "R6 cur unchanged", cur_page, 8'h41);
    chk(n_ovw == ovw0 + 1, "R6 ovw pulse", n_ovw, ovw0 + 1);
    chk(miss_cnt == 8'd1, "R6 miss count", miss_cnt, 1);
    chk(rst_flag == 1'b1, "R7 flag set", rst_flag, 1);
    cfg(3'd3, 8'h42);
    chk(rst_flag == 1'b1, "R7 same boundary keeps flag", rst_flag, 1);
    cfg(3'd3, 8'h46);
    chk(rst_flag == 1'b0, "R7 moved boundary clears flag", rst_flag, 0);
    // R6: start with current page equal to boundary
    cfg(3'd3, 8'h41);
    send(10, 1'b0, 1'b0, 1);
    chk(n_ovw == ovw0 + 2, "R6 immediate overrun", n_ovw, ovw0 + 2);
    chk(miss_cnt == 8'd2 && rst_flag, "R6 immediate miss and flag", miss_cnt, 2);
    cfg(3'd3, 8'h46);
    // R8 R9: monitor mode
    cfg(3'd4, 8'h01);
    chk(rx_disabled == 1'b1, "R8 rx_disabled", rx_disabled, 1);
    while (m_miss != 8'd130) send(5, 1'b0, 1'b0, 2);
    chk(miss_cnt == 8'd130, "R8 monitor frames counted", miss_cnt, 130);
    chk(n_ovf == 1, "R9 single overflow pulse", n_ovf, 1);
    chk(cur_page == 8'h41, "R8 cur unchanged", cur_page, 8'h41);
    cfg(3'd4, 8'h00);
    chk(rx_disabled == 1'b0, "R8 rx_disabled off", rx_disabled, 0);
    // R3: group flag in status byte
    send(8, 1'b1, 1'b0, 77);
    chk(cur_page == 8'h42, "R3 group frame stored", cur_page, 8'h42);
    chk(sbq.size() == 0, "R2 all expected writes seen", sbq.size(), 0);
    chk(n_ok == 5, "R4 ok pulse count", n_ok, 5);
    chk(n_miss == 130, "R6 missed pulse count", n_miss, 130);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule